// File: doc/BRIEF.md
# Flash Endurance Fault Injector

This block runs next to a behavioural flash array model and decides, for each operation presented to it, whether that operation should report failure. Every event carries an operation kind (read, program or erase) and an absolute page number (read and program) or block number (erase). No partitioning is applied to either number. The verdict comes back one cycle after the event.

Failures come from four fixed tables, all set through parameters. The first is a list of bad blocks that are bad from reset. The second holds weak blocks that survive only a limited number of erases. The third holds weak pages that accept only a limited number of programs. The fourth holds data-losing pages that return data only a limited number of times. Each table entry has an enable bit, an address, a limit and its own use counter. The block also keeps a saturating erase count per block and a running total of erases. Every time a set number of erases has been counted across the whole device, it raises a one-cycle wear-report strobe.

Top module: `wear_fault_injector`

## Requirements
- R1: `fail_vld` is high in exactly the cycle after each cycle with `ev_valid` high, and low otherwise. `fail` is high only together with `fail_vld`.
- R2: `ev_op` encodes 2'b00 read, 2'b01 program, 2'b10 erase and 2'b11 no operation. A no-operation event still gets `fail_vld`, but it never fails and counts nothing.
- R3: An operation of any kind on a block in the bad list fails from the first cycle after reset. For read and program, the block is the page number shifted right by `PG_SHIFT` (default 2). For erase, it is the low `BLK_W` bits of `ev_addr`. The defaults list blocks 3 and 9.
- R4: An enabled weak-block entry with limit L lets the first L erases of its block pass. Every later erase of that block fails. The defaults are block 5 with limit field 0 and block 12 with limit 1.
- R5: An enabled weak-page entry with limit L lets the first L programs of its page pass. Later programs of that page fail. The defaults are page 20 with limit field 0 and page 40 with limit 2.
- R6: An enabled data-losing page entry with limit L lets the first L reads of its page pass. Later reads of that page fail. The defaults are page 30 with limit 1 and page 50 with limit field 0.
- R7: A limit field of 0 means a limit of 3.
- R8: Each table counts only its own operation kind. A disabled entry never causes a failure; by default the entry for page 60 is disabled. An event that matches no enabled entry and no bad block never fails.
- R9: `total_erases` rises by one in the cycle after each erase event, whether or not the erase fails.
- R10: When `WEAR_INTERVAL` (default 5) is non-zero, `wear_rpt` pulses for one cycle, alongside `fail_vld`, for every WEAR_INTERVAL-th erase counted since reset. When it is zero, `wear_rpt` stays low.
- R11: After an erase event, `blk_wear` shows that block's erase count including this erase, saturating at all ones. It holds its value otherwise.
- R12: During and right after reset, `fail_vld`, `fail`, `wear_rpt`, `blk_wear` and `total_erases` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe |
| ev_op | input | 2 | Operation kind |
| ev_addr | input | ADDR_W | Page number, or block number for erase |
| fail_vld | output | 1 | Verdict valid, one cycle after the event |
| fail | output | 1 | Operation should report failure |
| wear_rpt | output | 1 | One-cycle wear-report strobe |
| blk_wear | output | CNT_W | Erase count of the block just erased |
| total_erases | output | TOT_W | Erases seen since reset |

## Verification
Two outputs can change in the same cycle: the wear-report strobe and a failing erase verdict. The bench arranges the fifth erase since reset to be the fourth erase of weak block 5. That erase both exhausts the block's budget and completes a report interval, so `fail` and `wear_rpt` must be high together, and `total_erases` must still advance. The tenth erase then lands on an ordinary block, which shows that the strobe does not depend on a failure. A behavioural model runs alongside the design, and the bench compares every output against it on every clock.

// File: rtl/ewf_pkg.sv
package ewf_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_PROG  = 2'b01,
      OP_ERASE = 2'b10,
      OP_NONE  = 2'b11
   } ewf_op_e;

   localparam int unsigned DEFAULT_LIMIT = 3;

   function automatic int unsigned eff_limit(input int unsigned lim);
      return (lim == 0) ? DEFAULT_LIMIT : lim;
   endfunction
endpackage

// File: rtl/endur_table.sv
module endur_table #(
   parameter int N     = 2,
   parameter int KEY_W = 8,
   parameter int LIM_W = 4,
   parameter logic [N-1:0][KEY_W-1:0] KEYS = '0,
   parameter logic [N-1:0][LIM_W-1:0] LIMS = '0,
   parameter logic [N-1:0]            EN   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             probe,
   input  logic [KEY_W-1:0] key,
   output logic             deny
);
   logic [N-1:0] hit;
   logic [N-1:0] spent;

   if (LIM_W < 2) begin : g_bad_lim_w
      $error("endur_table: LIM_W must hold the default limit");
   end

   for (genvar i = 0; i < N; i++) begin : g_ent
      localparam int unsigned LIM_EFF = ewf_pkg::eff_limit(int'(LIMS[i]));
      logic [LIM_W-1:0] done_q;

      assign hit[i]   = EN[i] && (key == KEYS[i]);
      assign spent[i] = (done_q >= LIM_W'(LIM_EFF));

      always_ff @(posedge clk) begin
         if (!rst_n)
            done_q <= '0;
         else if (probe && hit[i] && !spent[i])
            done_q <= done_q + 1'b1;
      end
   end

   assign deny = |(hit & spent);
endmodule

// File: rtl/wear_tracker.sv
module wear_tracker #(
   parameter int BLK_W    = 6,
   parameter int CNT_W    = 8,
   parameter int TOT_W    = 16,
   parameter int INTERVAL = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             erase_evt,
   input  logic [BLK_W-1:0] blk,
   output logic [CNT_W-1:0] cnt_next,
   output logic             rpt_hit,
   output logic [TOT_W-1:0] total
);
   localparam int NUM_BLK = 1 << BLK_W;

   logic [CNT_W-1:0] wear_q [NUM_BLK];
   logic [TOT_W-1:0] total_q;

   assign cnt_next = (&wear_q[blk]) ? wear_q[blk] : wear_q[blk] + 1'b1;
   assign total    = total_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BLK; b++) wear_q[b] <= '0;
         total_q <= '0;
      end else if (erase_evt) begin
         wear_q[blk] <= cnt_next;
         total_q     <= total_q + 1'b1;
      end
   end

   if (INTERVAL == 0) begin : g_no_rpt
      assign rpt_hit = 1'b0;
   end else begin : g_rpt
      localparam int IV_W = $clog2(INTERVAL + 1);
      logic [IV_W-1:0] iv_q;

      assign rpt_hit = erase_evt && (iv_q == IV_W'(INTERVAL - 1));

      always_ff @(posedge clk) begin
         if (!rst_n)
            iv_q <= '0;
         else if (rpt_hit)
            iv_q <= '0;
         else if (erase_evt)
            iv_q <= iv_q + 1'b1;
      end
   end
endmodule

// File: rtl/wear_fault_injector.sv
module wear_fault_injector #(
   parameter int ADDR_W   = 8,
   parameter int PG_SHIFT = 2,
   parameter int LIM_W    = 4,
   parameter int CNT_W    = 8,
   parameter int TOT_W    = 16,
   parameter int WEAR_INTERVAL = 5,
   parameter int NUM_BAD = 2,
   parameter logic [NUM_BAD-1:0][ADDR_W-PG_SHIFT-1:0] BAD_BLK = {6'd9, 6'd3},
   parameter int NUM_WB = 2,
   parameter logic [NUM_WB-1:0][ADDR_W-PG_SHIFT-1:0] WB_BLK = {6'd12, 6'd5},
   parameter logic [NUM_WB-1:0][LIM_W-1:0] WB_LIM = {4'd1, 4'd0},
   parameter logic [NUM_WB-1:0]            WB_EN  = 2'b11,
   parameter int NUM_WP = 2,
   parameter logic [NUM_WP-1:0][ADDR_W-1:0] WP_PAGE = {8'd40, 8'd20},
   parameter logic [NUM_WP-1:0][LIM_W-1:0]  WP_LIM  = {4'd2, 4'd0},
   parameter logic [NUM_WP-1:0]             WP_EN   = 2'b11,
   parameter int NUM_GP = 3,
   parameter logic [NUM_GP-1:0][ADDR_W-1:0] GP_PAGE = {8'd60, 8'd50, 8'd30},
   parameter logic [NUM_GP-1:0][LIM_W-1:0]  GP_LIM  = {4'd1, 4'd0, 4'd1},
   parameter logic [NUM_GP-1:0]             GP_EN   = 3'b011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [1:0]        ev_op,
   input  logic [ADDR_W-1:0] ev_addr,
   output logic              fail_vld,
   output logic              fail,
   output logic              wear_rpt,
   output logic [CNT_W-1:0]  blk_wear,
   output logic [TOT_W-1:0]  total_erases
);
   import ewf_pkg::*;

   localparam int BLK_W = ADDR_W - PG_SHIFT;

   if (PG_SHIFT < 0 || PG_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("wear_fault_injector: PG_SHIFT out of range");
   end
   if (WEAR_INTERVAL < 0) begin : g_bad_iv
      $error("wear_fault_injector: WEAR_INTERVAL negative");
   end

   ewf_op_e          op;
   logic             is_rd, is_pg, is_er;
   logic [BLK_W-1:0] blk;
   logic [NUM_BAD-1:0] bad_hit;
   logic             bad_any, wb_deny, wp_deny, gp_deny;
   logic [CNT_W-1:0] cnt_next;
   logic             rpt_hit;

   assign op    = ewf_op_e'(ev_op);
   assign is_rd = ev_valid && (op == OP_READ);
   assign is_pg = ev_valid && (op == OP_PROG);
   assign is_er = ev_valid && (op == OP_ERASE);
   assign blk   = (op == OP_ERASE) ? ev_addr[BLK_W-1:0] : ev_addr[ADDR_W-1:PG_SHIFT];

   for (genvar i = 0; i < NUM_BAD; i++) begin : g_bad
      assign bad_hit[i] = (blk == BAD_BLK[i]);
   end
   assign bad_any = (|bad_hit) && (op != OP_NONE);

   endur_table #(.N(NUM_WB), .KEY_W(BLK_W), .LIM_W(LIM_W),
                 .KEYS(WB_BLK), .LIMS(WB_LIM), .EN(WB_EN)) wb_tab_i (
      .clk(clk), .rst_n(rst_n), .probe(is_er), .key(blk), .deny(wb_deny));

   endur_table #(.N(NUM_WP), .KEY_W(ADDR_W), .LIM_W(LIM_W),
                 .KEYS(WP_PAGE), .LIMS(WP_LIM), .EN(WP_EN)) wp_tab_i (
      .clk(clk), .rst_n(rst_n), .probe(is_pg), .key(ev_addr), .deny(wp_deny));

   endur_table #(.N(NUM_GP), .KEY_W(ADDR_W), .LIM_W(LIM_W),
                 .KEYS(GP_PAGE), .LIMS(GP_LIM), .EN(GP_EN)) gp_tab_i (
      .clk(clk), .rst_n(rst_n), .probe(is_rd), .key(ev_addr), .deny(gp_deny));

   wear_tracker #(.BLK_W(BLK_W), .CNT_W(CNT_W), .TOT_W(TOT_W),
                  .INTERVAL(WEAR_INTERVAL)) wear_i (
      .clk(clk), .rst_n(rst_n), .erase_evt(is_er), .blk(blk),
      .cnt_next(cnt_next), .rpt_hit(rpt_hit), .total(total_erases));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fail_vld <= 1'b0;
         fail     <= 1'b0;
         wear_rpt <= 1'b0;
         blk_wear <= '0;
      end else begin
         fail_vld <= ev_valid;
         fail     <= ev_valid && (bad_any || (is_er && wb_deny) ||
                                  (is_pg && wp_deny) || (is_rd && gp_deny));
         wear_rpt <= rpt_hit;
         if (is_er) blk_wear <= cnt_next;
      end
   end
endmodule

// File: rtl/ewf_checker.sv
module ewf_checker #(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 8,
   parameter int TOT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_valid,
   input logic [1:0]        ev_op,
   input logic [ADDR_W-1:0] ev_addr,
   input logic              fail_vld,
   input logic              fail,
   input logic              wear_rpt,
   input logic [CNT_W-1:0]  blk_wear,
   input logic [TOT_W-1:0]  total_erases
);
   // R1
   verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |=> fail_vld);
   // R1
   no_spurious_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> !fail_vld);
   // R1
   fail_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> fail_vld);
   // R2
   nop_never_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_op == 2'b11) |=> !fail);
   // R9
   erase_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_op == 2'b10) |=> total_erases == TOT_W'($past(total_erases) + 1'b1));
   // R9
   total_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_valid && ev_op == 2'b10) |=> $stable(total_erases));
   // R10
   rpt_after_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_valid && ev_op == 2'b10) |=> !wear_rpt);
   // R11
   blk_wear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_valid && ev_op == 2'b10) |=> $stable(blk_wear));
endmodule

bind wear_fault_injector ewf_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TOT_W(TOT_W)) chk_i (.*);

// File: tb/wear_fault_injector_tb_top.sv
module wear_fault_injector_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [1:0]  ev_op = 2'b11;
   logic [7:0]  ev_addr = '0;
   logic        fail_vld, fail, wear_rpt;
   logic [7:0]  blk_wear;
   logic [15:0] total_erases;

   int total_chk = 0;
   int bad_chk = 0;
   bit done = 0;

   // reference model state
   int wb5 = 0, wb12 = 0, wp20 = 0, wp40 = 0, gp30 = 0, gp50 = 0;
   int blk_cnt [64];
   int m_total = 0, m_iv = 0;
   bit exp_vld = 0, exp_fail = 0, exp_rpt = 0;
   int exp_bw = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wear_fault_injector dut_i (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op), .ev_addr(ev_addr),
      .fail_vld(fail_vld), .fail(fail), .wear_rpt(wear_rpt),
      .blk_wear(blk_wear), .total_erases(total_erases));

   task automatic chk(input string tag, input int act, input int exp);
      total_chk++;
      if (act != exp) begin
         bad_chk++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // spends one use of an entry: returns 1 when the budget was already used up
   function automatic bit spend(ref int used, input int lim);
      if (used >= lim) return 1;
      used++;
      return 0;
   endfunction

   task automatic model(input bit v, input logic [1:0] op, input int addr);
      int blk;
      bit f;
      exp_vld = v; exp_fail = 0; exp_rpt = 0;
      if (!v || op == 2'b11) return;
      blk = (op == 2'b10) ? (addr % 64) : (addr / 4);
      f = (blk == 3 || blk == 9);
      case (op)
         2'b10: begin
            if (blk == 5)  f |= spend(wb5, 3);
            if (blk == 12) f |= spend(wb12, 1);
            m_total++;
            if (blk_cnt[blk] < 255) blk_cnt[blk]++;
            exp_bw = blk_cnt[blk];
            m_iv++;
            if (m_iv == 5) begin exp_rpt = 1; m_iv = 0; end
         end
         2'b01: begin
            if (addr == 20) f |= spend(wp20, 3);
            if (addr == 40) f |= spend(wp40, 2);
         end
         default: begin
            if (addr == 30) f |= spend(gp30, 1);
            if (addr == 50) f |= spend(gp50, 3);
         end
      endcase
      exp_fail = f;
   endtask

   task automatic step(input bit v, input logic [1:0] op, input int addr, input string tag);
      model(v, op, addr);
      ev_valid = v; ev_op = op; ev_addr = addr[7:0];
      @(negedge clk);
      ev_valid = 0;
      chk({"R1 fail_vld ", tag}, fail_vld, exp_vld);
      chk(tag, fail, exp_fail);
      chk({"R10 wear_rpt ", tag}, wear_rpt, exp_rpt);
      chk({"R9 total ", tag}, total_erases, m_total);
      chk({"R11 blk_wear ", tag}, blk_wear, exp_bw);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         bad_chk++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < 64; b++) blk_cnt[b] = 0;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 fail_vld", fail_vld, 0);
      chk("R12 fail", fail, 0);
      chk("R12 wear_rpt", wear_rpt, 0);
      chk("R12 blk_wear", blk_wear, 0);
      chk("R12 total", total_erases, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 after release", fail_vld, 0);

      step(0, 2'b00, 0, "R1 idle");
      step(1, 2'b00, 0, "R8 unmatched read");
      step(1, 2'b01, 12, "R3 program bad block 3");
      step(1, 2'b00, 37, "R3 read bad block 9");
      step(1, 2'b11, 12, "R2 nop on bad block");
      step(1, 2'b01, 21, "R8 program in weak block");
      step(1, 2'b00, 21, "R8 read in weak block");
      // erases: tot1 bad block, then block 5 four times
      step(1, 2'b10, 3, "R3 erase bad block");
      step(1, 2'b10, 5, "R4 R7 erase 1 of block 5");
      step(1, 2'b10, 5, "R4 R7 erase 2 of block 5");
      step(1, 2'b10, 5, "R4 R7 erase 3 of block 5");
      // fifth erase overall: fail and wear report together
      step(1, 2'b10, 5, "R4 R10 erase 4 of block 5");
      step(0, 2'b10, 5, "R10 idle after report");
      step(1, 2'b10, 12, "R4 erase 1 of block 12");
      step(1, 2'b10, 12, "R4 erase 2 of block 12");
      step(1, 2'b10, 12, "R4 erase 3 of block 12");
      for (int k = 0; k < 5; k++) step(1, 2'b01, 20, "R5 R7 program page 20");
      for (int k = 0; k < 3; k++) step(1, 2'b01, 40, "R5 program page 40");
      step(1, 2'b00, 20, "R8 read of weak page");
      for (int k = 0; k < 3; k++) step(1, 2'b00, 30, "R6 read page 30");
      for (int k = 0; k < 5; k++) step(1, 2'b00, 50, "R6 R7 read page 50");
      for (int k = 0; k < 3; k++) step(1, 2'b00, 60, "R8 disabled entry");
      step(1, 2'b01, 30, "R8 program of data-losing page");
      for (int k = 0; k < 4; k++) step(1, 2'b10, 7, "R10 R11 erase block 7");
      step(1, 2'b11, 7, "R2 nop counts nothing");
      step(0, 2'b00, 0, "R1 final idle");

      done = 1;
      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
   end
endmodule